// File: doc/BRIEF.md
# Two-Branch Interrupt Aggregation Controller

This block collects interrupt events from an Ethernet switch and drives one active-high interrupt request pin. Events arrive on two branches. The timestamp branch has nine capture and timer sources. All nine share one register, which holds both their sticky status bits and their enables. The switch-fabric branch has three tiers. At the bottom sit the buffer-manager, switch-engine and per-port MAC sub-module registers. A fabric-level pending/mask pair sits above them. Above that is a fixed bit of the top-level status word.

Software reaches every register through a word-addressed bus. A write takes one cycle, and read data is a combinational function of the address. Every intermediate and top-level pending bit is an OR of the enabled bits one tier below. Clearing the leaf bits therefore clears the whole path. A two-state output machine registers the pin: it moves to `OUT_RAISED` from `OUT_QUIET` when the qualifying condition is present, and moves back to `OUT_QUIET` when the condition is gone.

Register map by word address: 0 top status, 1 top enable, 2 output configuration, 3 timestamp status/enable, 4 fabric pending, 5 fabric mask, 6 buffer-manager pending, 7 buffer-manager mask, 8 switch-engine pending, 9 switch-engine mask. For MAC port p, the pending register sits at 10+2p and the mask register at 11+2p.

Top module: `irqagg_ctrl`

## Requirements
- R1: Top status (address 0) bit 29 reads 1 exactly when some timestamp status bit and its enable are both set.
- R2: Top status bit 28 reads 1 exactly when some fabric pending bit (address 4) and its fabric mask bit (address 5) are both set.
- R3: When output configuration (address 2) bit 8 is 0, the pin is 0 one cycle later, whatever the other registers hold.
- R4: Timestamp register (address 3) bits 8:0 are sticky status bits. They are set by source pulses in this order: port0 tx, port0 rx, port1 tx, port1 rx, port2 tx, port2 rx, gpio8, gpio9, timer. Writing 1 to a status bit clears it. Bits 24:16 are the read/write enables in the same order.
- R5: If a source pulse and a write-1 clear hit the same leaf bit in the same cycle, the bit ends up set.
- R6: Buffer-manager pending (address 6) holds status A in bit 0 and status B in bit 1. Switch-engine pending (address 8) holds its one source in bit 0. Both are write-1-to-clear, and each has a mask register in the same bit positions.
- R7: Fabric pending (address 4) reads buffer-manager bit 0 and switch-engine bit 1, then MAC ports 0..2 in bits 2..4. Each of these bits is the OR of its sub-module's pending-and-mask bits.
- R8: MAC pending registers always read 0, and writes to them have no effect. MAC mask registers store bit 0.
- R9: One cycle after (cfg bit8 AND ((top bit29 AND enable bit29) OR (top bit28 AND enable bit28))), the pin equals that expression.
- R10: Top status is read-only. Writes to address 0 change nothing.
- R11: After reset all registers read 0 and the pin is 0.
- R12: Top enable (address 1) stores bits 29 and 28. Each gates its own top status bit onto the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register word address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| ts_src | input | 2*PORTS+3 | Timestamp-branch source pulses |
| bm_src | input | 2 | Buffer-manager source pulses (A, B) |
| se_src | input | 1 | Switch-engine source pulse |
| irq | output | 1 | Registered active-high interrupt request |

## Verification
The bench builds the block with its defaults: 32-bit data, 5-bit addresses and three MAC ports. With these values the whole map fits in addresses 0 to 15, so a random 4-bit address reaches every register, including every MAC pending and mask pair. The 32-bit word also holds the fixed top-level bits 29, 28 and 8, so random writes switch each tier's enable on and off while sparse source pulses arrive. This exposes both the set-versus-clear collisions and the cycle-by-cycle pin behaviour to the reference model.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    localparam int TOP_TS_BIT  = 29;
    localparam int TOP_FAB_BIT = 28;
    localparam int CFG_OE_BIT  = 8;
    localparam int TS_EN_SHIFT = 16;
    localparam int BM_N        = 2;
    localparam int SE_N        = 1;

    localparam int A_TOP_STAT = 0;
    localparam int A_TOP_EN   = 1;
    localparam int A_CFG      = 2;
    localparam int A_TS       = 3;
    localparam int A_FAB_PEND = 4;
    localparam int A_FAB_MASK = 5;
    localparam int A_BM_PEND  = 6;
    localparam int A_BM_MASK  = 7;
    localparam int A_SE_PEND  = 8;
    localparam int A_SE_MASK  = 9;
    localparam int A_MAC_BASE = 10;

    typedef enum logic {
        OUT_QUIET  = 1'b0,
        OUT_RAISED = 1'b1
    } irq_state_e;

    function automatic int mac_pend_addr(input int p);
        return A_MAC_BASE + 2 * p;
    endfunction

    function automatic int mac_mask_addr(input int p);
        return A_MAC_BASE + 2 * p + 1;
    endfunction

endpackage

// File: rtl/irqagg_leaf_bank.sv
module irqagg_leaf_bank #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    input  logic         clr_we,
    input  logic [W-1:0] clr_bits,
    input  logic         mask_we,
    input  logic [W-1:0] mask_bits,
    output logic [W-1:0] status,
    output logic [W-1:0] mask,
    output logic         any
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                status[i] <= 1'b0;
            end else if (src[i]) begin
                status[i] <= 1'b1;
            end else if (clr_we && clr_bits[i]) begin
                status[i] <= 1'b0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask[i] <= 1'b0;
            end else if (mask_we) begin
                mask[i] <= mask_bits[i];
            end
        end
    end

    assign any = |(status & mask);

endmodule

// File: rtl/irqagg_fabric_tier.sv
module irqagg_fabric_tier #(
    parameter int PORTS = 3,
    localparam int FAB_N = 2 + PORTS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bm_any,
    input  logic             se_any,
    input  logic [PORTS-1:0] mac_any,
    input  logic             mask_we,
    input  logic [FAB_N-1:0] mask_bits,
    output logic [FAB_N-1:0] fab_pend,
    output logic [FAB_N-1:0] fab_mask,
    output logic             fab_any
);

    assign fab_pend = {mac_any, se_any, bm_any};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fab_mask <= '0;
        end else if (mask_we) begin
            fab_mask <= mask_bits;
        end
    end

    assign fab_any = |(fab_pend & fab_mask);

endmodule

// File: rtl/irqagg_out_fsm.sv
module irqagg_out_fsm
    import irqagg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic qualify,
    output logic irq
);

    irq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OUT_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_QUIET:  if (qualify)  state_d = OUT_RAISED;
            OUT_RAISED: if (!qualify) state_d = OUT_QUIET;
            default:    state_d = OUT_QUIET;
        endcase
    end

    always_comb begin
        irq = (state_q == OUT_RAISED);
    end

endmodule

// File: rtl/irqagg_ctrl.sv
module irqagg_ctrl
    import irqagg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5,
    parameter int PORTS  = 3,
    localparam int TS_N  = 2 * PORTS + 3,
    localparam int FAB_N = 2 + PORTS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [TS_N-1:0]   ts_src,
    input  logic [BM_N-1:0]   bm_src,
    input  logic [SE_N-1:0]   se_src,
    output logic              irq
);

    function automatic logic hit(input logic [ADDR_W-1:0] a, input int target);
        return a == ADDR_W'(target);
    endfunction

    logic wr_top_en, wr_cfg, wr_ts, wr_fab_mask;
    logic wr_bm_pend, wr_bm_mask, wr_se_pend, wr_se_mask;

    assign wr_top_en   = bus_we && hit(bus_addr, A_TOP_EN);
    assign wr_cfg      = bus_we && hit(bus_addr, A_CFG);
    assign wr_ts       = bus_we && hit(bus_addr, A_TS);
    assign wr_fab_mask = bus_we && hit(bus_addr, A_FAB_MASK);
    assign wr_bm_pend  = bus_we && hit(bus_addr, A_BM_PEND);
    assign wr_bm_mask  = bus_we && hit(bus_addr, A_BM_MASK);
    assign wr_se_pend  = bus_we && hit(bus_addr, A_SE_PEND);
    assign wr_se_mask  = bus_we && hit(bus_addr, A_SE_MASK);

    logic [TS_N-1:0] ts_status, ts_en;
    logic            ts_any;

    irqagg_leaf_bank #(.W(TS_N)) u_ts (
        .clk       (clk),
        .rst_n     (rst_n),
        .src       (ts_src),
        .clr_we    (wr_ts),
        .clr_bits  (bus_wdata[TS_N-1:0]),
        .mask_we   (wr_ts),
        .mask_bits (bus_wdata[TS_EN_SHIFT +: TS_N]),
        .status    (ts_status),
        .mask      (ts_en),
        .any       (ts_any)
    );

    logic [BM_N-1:0] bm_status, bm_mask;
    logic            bm_any;

    irqagg_leaf_bank #(.W(BM_N)) u_bm (
        .clk       (clk),
        .rst_n     (rst_n),
        .src       (bm_src),
        .clr_we    (wr_bm_pend),
        .clr_bits  (bus_wdata[BM_N-1:0]),
        .mask_we   (wr_bm_mask),
        .mask_bits (bus_wdata[BM_N-1:0]),
        .status    (bm_status),
        .mask      (bm_mask),
        .any       (bm_any)
    );

    logic [SE_N-1:0] se_status, se_mask;
    logic            se_any;

    irqagg_leaf_bank #(.W(SE_N)) u_se (
        .clk       (clk),
        .rst_n     (rst_n),
        .src       (se_src),
        .clr_we    (wr_se_pend),
        .clr_bits  (bus_wdata[SE_N-1:0]),
        .mask_we   (wr_se_mask),
        .mask_bits (bus_wdata[SE_N-1:0]),
        .status    (se_status),
        .mask      (se_mask),
        .any       (se_any)
    );

    logic [PORTS-1:0] mac_status, mac_mask, mac_any;

    for (genvar p = 0; p < PORTS; p++) begin : g_mac
        irqagg_leaf_bank #(.W(1)) u_mac (
            .clk       (clk),
            .rst_n     (rst_n),
            .src       (1'b0),
            .clr_we    (1'b0),
            .clr_bits  (1'b0),
            .mask_we   (bus_we && hit(bus_addr, mac_mask_addr(p))),
            .mask_bits (bus_wdata[0]),
            .status    (mac_status[p]),
            .mask      (mac_mask[p]),
            .any       (mac_any[p])
        );
    end

    logic [FAB_N-1:0] fab_pend, fab_mask;
    logic             fab_any;

    irqagg_fabric_tier #(.PORTS(PORTS)) u_fab (
        .clk       (clk),
        .rst_n     (rst_n),
        .bm_any    (bm_any),
        .se_any    (se_any),
        .mac_any   (mac_any),
        .mask_we   (wr_fab_mask),
        .mask_bits (bus_wdata[FAB_N-1:0]),
        .fab_pend  (fab_pend),
        .fab_mask  (fab_mask),
        .fab_any   (fab_any)
    );

    logic en_ts, en_fab, cfg_oe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_ts  <= 1'b0;
            en_fab <= 1'b0;
        end else if (wr_top_en) begin
            en_ts  <= bus_wdata[TOP_TS_BIT];
            en_fab <= bus_wdata[TOP_FAB_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_oe <= 1'b0;
        end else if (wr_cfg) begin
            cfg_oe <= bus_wdata[CFG_OE_BIT];
        end
    end

    logic qualify;
    assign qualify = cfg_oe && ((ts_any && en_ts) || (fab_any && en_fab));

    irqagg_out_fsm u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .qualify (qualify),
        .irq     (irq)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(A_TOP_STAT): begin
                bus_rdata[TOP_TS_BIT]  = ts_any;
                bus_rdata[TOP_FAB_BIT] = fab_any;
            end
            ADDR_W'(A_TOP_EN): begin
                bus_rdata[TOP_TS_BIT]  = en_ts;
                bus_rdata[TOP_FAB_BIT] = en_fab;
            end
            ADDR_W'(A_CFG):      bus_rdata[CFG_OE_BIT] = cfg_oe;
            ADDR_W'(A_TS): begin
                bus_rdata[TS_N-1:0]             = ts_status;
                bus_rdata[TS_EN_SHIFT +: TS_N]  = ts_en;
            end
            ADDR_W'(A_FAB_PEND): bus_rdata[FAB_N-1:0] = fab_pend;
            ADDR_W'(A_FAB_MASK): bus_rdata[FAB_N-1:0] = fab_mask;
            ADDR_W'(A_BM_PEND):  bus_rdata[BM_N-1:0]  = bm_status;
            ADDR_W'(A_BM_MASK):  bus_rdata[BM_N-1:0]  = bm_mask;
            ADDR_W'(A_SE_PEND):  bus_rdata[SE_N-1:0]  = se_status;
            ADDR_W'(A_SE_MASK):  bus_rdata[SE_N-1:0]  = se_mask;
            default: begin
                for (int p = 0; p < PORTS; p++) begin
                    if (hit(bus_addr, mac_pend_addr(p))) bus_rdata[0] = mac_status[p];
                    if (hit(bus_addr, mac_mask_addr(p))) bus_rdata[0] = mac_mask[p];
                end
            end
        endcase
    end

    logic unused_wdata;
    assign unused_wdata = ^bus_wdata;

endmodule

// File: rtl/irqagg_ctrl_chk.sv
module irqagg_ctrl_chk
    import irqagg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5,
    parameter int PORTS  = 3,
    localparam int TS_N  = 2 * PORTS + 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [TS_N-1:0]   ts_src,
    input logic [TS_N-1:0]   ts_status,
    input logic              cfg_oe,
    input logic              qualify,
    input logic              irq
);

    assert_setwins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|ts_src) |=> ((ts_status & $past(ts_src)) == $past(ts_src)));

    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == ADDR_W'(A_TS)) |=> ((ts_status & $past(ts_status)) == $past(ts_status)));

    assert_cfg_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_oe |=> !irq);

    assert_irq_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        qualify |=> irq);

    assert_irq_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !qualify |=> !irq);

    for (genvar p = 0; p < PORTS; p++) begin : g_mac_chk
        assert_macpend_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_addr == ADDR_W'(mac_pend_addr(p))) |-> (bus_rdata == '0));
    end

endmodule

bind irqagg_ctrl irqagg_ctrl_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .PORTS  (PORTS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .ts_src    (ts_src),
    .ts_status (ts_status),
    .cfg_oe    (cfg_oe),
    .qualify   (qualify),
    .irq       (irq)
);

// File: tb/sim_irqagg_ctrl.sv
`timescale 1ns/1ps
module sim_irqagg_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [8:0]  ts_src = '0;
    logic [1:0]  bm_src = '0;
    logic [0:0]  se_src = '0;
    logic        irq;

    always #5 clk = ~clk;

    irqagg_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ts_src(ts_src),
        .bm_src(bm_src), .se_src(se_src), .irq(irq)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // behavioural reference state
    logic [8:0] m_ts, m_tsen;
    logic [1:0] m_bm, m_bmm;
    logic       m_se, m_sem;
    logic [4:0] m_fabm;
    logic       m_en29, m_en28, m_cfg;
    logic [2:0] m_mac;
    logic       exp_irq;

    function automatic logic [31:0] model_read(input int a);
        logic [31:0] r;
        logic bm_p, se_p, ts_p, fab_p;
        bm_p  = |(m_bm & m_bmm);
        se_p  = m_se & m_sem;
        ts_p  = |(m_ts & m_tsen);
        fab_p = |({3'b000, se_p, bm_p} & m_fabm);
        r = '0;
        case (a)
            0: begin r[29] = ts_p; r[28] = fab_p; end
            1: begin r[29] = m_en29; r[28] = m_en28; end
            2: r[8] = m_cfg;
            3: begin r[8:0] = m_ts; r[24:16] = m_tsen; end
            4: r[4:0] = {3'b000, se_p, bm_p};
            5: r[4:0] = m_fabm;
            6: r[1:0] = m_bm;
            7: r[1:0] = m_bmm;
            8: r[0] = m_se;
            9: r[0] = m_sem;
            11, 13, 15: r[0] = m_mac[(a - 11) / 2];
            default: r = '0;
        endcase
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ts = '0; m_tsen = '0; m_bm = '0; m_bmm = '0; m_se = 0; m_sem = 0;
            m_fabm = '0; m_en29 = 0; m_en28 = 0; m_cfg = 0; m_mac = '0; exp_irq = 0;
        end else begin
            logic [31:0] st;
            st = model_read(0);
            exp_irq = m_cfg && ((st[29] && m_en29) || (st[28] && m_en28));
            if (bus_we) begin
                case (int'(bus_addr))
                    1: begin m_en29 = bus_wdata[29]; m_en28 = bus_wdata[28]; end
                    2: m_cfg = bus_wdata[8];
                    3: begin m_ts = m_ts & ~bus_wdata[8:0]; m_tsen = bus_wdata[24:16]; end
                    5: m_fabm = bus_wdata[4:0];
                    6: m_bm = m_bm & ~bus_wdata[1:0];
                    7: m_bmm = bus_wdata[1:0];
                    8: m_se = m_se & ~bus_wdata[0];
                    9: m_sem = bus_wdata[0];
                    11, 13, 15: m_mac[(int'(bus_addr) - 11) / 2] = bus_wdata[0];
                    default: ;
                endcase
            end
            m_ts = m_ts | ts_src;
            m_bm = m_bm | bm_src;
            m_se = m_se | se_src[0];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // pin compared with the model every cycle (R9, with R3 and R12 gating)
    always @(negedge clk) begin
        if (rst_n && !finished) chk("R9 pin", {31'b0, irq}, {31'b0, exp_irq});
    end

    task automatic step(input logic we, input int a, input logic [31:0] d,
                        input logic [8:0] ts, input logic [1:0] bm, input logic se);
        @(negedge clk);
        bus_we = we; bus_addr = 5'(a); bus_wdata = d;
        ts_src = ts; bm_src = bm; se_src = se;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        step(1'b1, a, d, '0, '0, 1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 0, '0, '0, '0, 1'b0);
    endtask

    task automatic rd(input string tag, input int a);
        step(1'b0, a, '0, '0, '0, 1'b0);
        #1;
        chk(tag, bus_rdata, model_read(a));
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 pin", {31'b0, irq}, 32'h0);
        for (int a = 0; a < 16; a++) begin
            bus_addr = 5'(a); #1;
            chk("R11 reset read", bus_rdata, 32'h0);
        end
        rst_n = 1'b1;
        idle(2);

        // R1 / R4 / R9: timestamp path, gpio9 source is bit 7
        wr(3, 32'h0080_0000);
        wr(1, 32'h2000_0000);
        wr(2, 32'h0000_0100);
        step(1'b0, 0, '0, 9'h080, '0, 1'b0);
        idle(1);
        chk("R9 one cycle later pin still low", {31'b0, irq}, 32'h0);
        idle(1);
        chk("R9 pin raised", {31'b0, irq}, 32'h1);
        rd("R1 top status bit29", 0);
        rd("R4 ts status/enable", 3);

        // R3: global enable off
        wr(2, 32'h0);
        idle(2);
        chk("R3 pin low with cfg off", {31'b0, irq}, 32'h0);
        wr(2, 32'h0000_0100);

        // R12: drop top enable bit 29
        wr(1, 32'h0);
        idle(2);
        chk("R12 pin low with top enable off", {31'b0, irq}, 32'h0);
        rd("R12 top enable", 1);
        wr(1, 32'h3000_0000);

        // R4: timer source bit 8 latched but disabled
        step(1'b0, 0, '0, 9'h100, '0, 1'b0);
        rd("R4 timer latched", 3);
        // R4: W1C clears gpio9 and timer
        wr(3, 32'h0080_0180);
        idle(1);
        rd("R4 w1c cleared", 3);
        rd("R1 bit29 clear", 0);

        // R5: set and clear same cycle on port0 tx (bit 0)
        step(1'b0, 0, '0, 9'h001, '0, 1'b0);
        step(1'b1, 3, 32'h0001_0001, 9'h001, '0, 1'b0);
        idle(1);
        rd("R5 set wins", 3);

        // R6 / R7 / R2: buffer manager status B, switch engine
        wr(3, 32'h0000_01FF);
        wr(7, 32'h2);
        wr(5, 32'h3);
        step(1'b0, 0, '0, '0, 2'b10, 1'b0);
        rd("R6 bm pending B", 6);
        rd("R7 fabric pending", 4);
        rd("R2 top bit28", 0);
        step(1'b0, 0, '0, '0, 2'b01, 1'b1);
        rd("R6 se pending", 8);
        rd("R7 se not masked", 4);
        wr(9, 32'h1);
        idle(1);
        rd("R7 se masked in", 4);
        wr(6, 32'h3);
        wr(8, 32'h1);
        idle(2);
        rd("R2 bit28 cleared", 0);

        // R8: MAC registers
        wr(10, 32'hFFFF_FFFF);
        wr(13, 32'h1);
        rd("R8 mac pend zero", 10);
        rd("R8 mac mask", 13);
        rd("R8 mac pend p1 zero", 12);

        // R10: writes to top status ignored
        step(1'b0, 0, '0, 9'h002, '0, 1'b0);
        wr(0, 32'hFFFF_FFFF);
        rd("R10 top status unchanged", 0);
        rd("R10 ts unaffected", 3);

        // random mix against the model
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] d;
            d = $urandom;
            step(($urandom % 4) == 0, int'($urandom % 16), d,
                 (($urandom % 6) == 0) ? 9'($urandom) : 9'h0,
                 (($urandom % 6) == 0) ? 2'($urandom) : 2'h0,
                 ($urandom % 7) == 0);
            if ((i % 50) == 0) rd("R7 random readback", int'($urandom % 16));
        end
        idle(2);
        for (int a = 0; a < 16; a++) rd("R4 final readback", a);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule